// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic core of an accumulator-based processor datapath. A single operation code picks one of eighteen functions, and those functions work on the accumulator value and a second operand. The block drives the 8-bit result, a result-write enable and the five status flags that the operation would produce. The result path is purely combinational. The status flags are kept in a five-bit register inside the block. That register loads the computed flags on a rising clock edge when its update strobe is high.

The operations are binary addition and subtraction, each with and without an incoming carry or borrow. There are also bitwise AND, XOR and OR, a compare, increment and decrement, four single-bit accumulator rotates, accumulator complement, carry set and carry complement, and a packed-BCD correction step that follows an addition. Compare and the two carry operations leave the accumulator alone: for these the write enable stays low. The flag register supplies the incoming carry and the nibble carry, so a chain of operations behaves as it would inside a processor.

Top module: `acc_alu`

## Requirements
- R1: The flag vector holds sign at bit 4, zero at bit 3, nibble carry at bit 2, parity at bit 1 and carry at bit 0. `flags_o` resets asynchronously to 0 and loads `next_flags_o` on a rising edge when `flag_we_i` is 1. When `flag_we_i` is 0 it holds its value.
- R2: For add, add-with-carry, subtract, subtract-with-borrow, compare, AND, XOR, OR, increment, decrement and decimal adjust, the flags are computed from `result_o`. Zero is 1 exactly when the result is 0. Sign equals bit 7. Parity is 1 exactly when the result has an even number of one bits.
- R3: Op 0 (add) gives A+B and op 1 (add with carry) gives A+B+carry. Carry is the carry out of bit 7. Nibble carry is the carry out of bit 3.
- R4: Op 2 (subtract) gives A-B and op 3 (subtract with borrow) gives A-B-carry. Carry is 1 when the full result needs a borrow. Nibble carry is 1 when the low four bits need a borrow.
- R5: Op 7 (compare) sets every flag and drives `result_o` exactly as subtract does. It holds `res_we_o` at 0.
- R6: Op 8 (increment) gives A+1 and op 9 (decrement) gives A-1. Nibble carry is set when the low four bits were 0xF (increment) or 0x0 (decrement). Carry keeps its current value.
- R7: Op 4 (AND), op 5 (XOR) and op 6 (OR) give the bitwise result and clear both carry and nibble carry.
- R8: Op 10 rotates left with bit 7 going to bit 0 and to carry. Op 11 rotates right with bit 0 going to bit 7 and to carry. Op 12 rotates left through carry and op 13 rotates right through carry: the old carry fills the vacated bit and the outgoing bit becomes carry. The rotates change no other flag.
- R9: Op 14 writes the bitwise inverse of A and changes no flag. Op 15 sets carry, op 16 inverts carry, and neither changes any other flag or writes the result.
- R10: Op 17 (decimal adjust) first adds 0x06 if the low nibble is above 9 or nibble carry is set. The nibble carry becomes the carry out of bit 3 of that step, or 0 if the step does not apply. It then adds 0x60 if the first step overflowed 8 bits, the high nibble is above 9, or carry is set. Carry becomes 1 exactly when this second step applies.
- R11: Op codes 18 to 31 drive `result_o` equal to A and `res_we_o` at 0, and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| flag_we_i | input | 1 | Flag register update strobe |
| result_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result should be written to the accumulator |
| next_flags_o | output | 5 | Flags the operation produces |
| flags_o | output | 5 | Registered flags |

## Verification
The only internal state is the flag register. A wrong carry or nibble-carry bit in it shows up at `next_flags_o` and `result_o` in the same cycle on the next carry-consuming operation: add or subtract with carry, a through-carry rotate, decimal adjust or carry complement. A missed or stray load shows at `flags_o` one edge after the strobe. The stimulus toggles the strobe at random across all 32 op codes so that stale flags feed later operations. It also drives directed corners: 8-bit wrap, nibble boundaries and decimal-adjust overflow.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int FW = 5;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RL  = 5'd10, OP_RR  = 5'd11,
    OP_RLT = 5'd12, OP_RRT = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC = 5'd16, OP_DAA = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  typedef enum logic [1:0] {LG_AND = 2'd0, LG_XOR = 2'd1, LG_OR = 2'd2} logic_sel_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,   // carry in, or borrow in when sub_i
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,  // carry out, or borrow out when sub_i
  output logic          hc_o     // nibble carry, or nibble borrow when sub_i
);
  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   full;
  logic [NW:0]   low;

  // subtraction as a + ~b + ~borrow; carry out inverts to borrow
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
  assign low   = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};

  assign sum_o  = full[DW-1:0];
  assign cout_o = full[DW] ^ sub_i;
  assign hc_o   = low[NW] ^ sub_i;
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic_sel_e    sel_i,
  output logic [DW-1:0] y_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_AND:  y_o[i] = a_i[i] & b_i[i];
        LG_XOR:  y_o[i] = a_i[i] ^ b_i[i];
        default: y_o[i] = a_i[i] | b_i[i];
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_rot.sv
module acc_alu_rot #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  input  logic          right_i,
  input  logic          thru_i,
  output logic [DW-1:0] y_o,
  output logic          cout_o
);
  logic fill;

  always_comb begin
    if (right_i) begin
      cout_o = a_i[0];
      fill   = thru_i ? cin_i : a_i[0];
      y_o    = {fill, a_i[DW-1:1]};
    end else begin
      cout_o = a_i[DW-1];
      fill   = thru_i ? cin_i : a_i[DW-1];
      y_o    = {a_i[DW-2:0], fill};
    end
  end
endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa #(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic          ac_i,
  input  logic          cy_i,
  output logic [DW-1:0] y_o,
  output logic          ac_o,
  output logic          cy_o
);
  logic          fix_lo;
  logic          fix_hi;
  logic [NW:0]   lo_sum;
  logic [DW:0]   step1;
  logic [DW-1:0] hi_add;

  assign fix_lo = (a_i[NW-1:0] > NW'(9)) | ac_i;
  assign lo_sum = {1'b0, a_i[NW-1:0]} + (NW+1)'(6);
  assign step1  = {1'b0, a_i} + (fix_lo ? (DW+1)'(6) : '0);
  assign ac_o   = fix_lo & lo_sum[NW];
  // high correction looks at the nibble after the low fix-up
  assign fix_hi = step1[DW] | (step1[DW-1:NW] > NW'(9)) | cy_i;
  assign hi_add = fix_hi ? {NW'(6), NW'(0)} : '0;
  assign y_o    = step1[DW-1:0] + hi_add;
  assign cy_o   = fix_hi;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          flag_we_i,
  output logic [DW-1:0] result_o,
  output logic          res_we_o,
  output logic [FW-1:0] next_flags_o,
  output logic [FW-1:0] flags_o
);
  alu_op_e op;
  flags_t  flags_q, flags_d;

  assign op = alu_op_e'(op_i);

  // adder operand steering
  logic [DW-1:0] as_b, as_sum;
  logic          as_cin, as_sub, as_cout, as_hc;

  always_comb begin
    as_b   = opnd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_ADC:         as_cin = flags_q.cy;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin
        as_sub = 1'b1;
        as_cin = flags_q.cy;
      end
      OP_INC:         as_b = DW'(1);
      OP_DEC: begin
        as_b   = DW'(1);
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  acc_alu_addsub #(.DW(DW), .NW(NW)) u_addsub (
    .a_i    (acc_i),
    .b_i    (as_b),
    .cin_i  (as_cin),
    .sub_i  (as_sub),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .hc_o   (as_hc)
  );

  logic_sel_e    lg_sel;
  logic [DW-1:0] lg_y;

  always_comb begin
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_OR;
    endcase
  end

  acc_alu_logic #(.DW(DW)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (lg_sel),
    .y_o   (lg_y)
  );

  logic [DW-1:0] rot_y;
  logic          rot_cy;

  acc_alu_rot #(.DW(DW)) u_rot (
    .a_i     (acc_i),
    .cin_i   (flags_q.cy),
    .right_i (op == OP_RR || op == OP_RRT),
    .thru_i  (op == OP_RLT || op == OP_RRT),
    .y_o     (rot_y),
    .cout_o  (rot_cy)
  );

  logic [DW-1:0] daa_y;
  logic          daa_ac, daa_cy;

  acc_alu_daa #(.DW(DW), .NW(NW)) u_daa (
    .a_i  (acc_i),
    .ac_i (flags_q.ac),
    .cy_i (flags_q.cy),
    .y_o  (daa_y),
    .ac_o (daa_ac),
    .cy_o (daa_cy)
  );

  // result select and flag merge
  logic szp_upd;

  always_comb begin
    result_o = acc_i;
    res_we_o = 1'b1;
    flags_d  = flags_q;
    szp_upd  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        result_o   = as_sum;
        flags_d.cy = as_cout;
        flags_d.ac = as_hc;
        szp_upd    = 1'b1;
      end
      OP_CMP: begin
        result_o   = as_sum;
        res_we_o   = 1'b0;
        flags_d.cy = as_cout;
        flags_d.ac = as_hc;
        szp_upd    = 1'b1;
      end
      OP_INC, OP_DEC: begin
        result_o   = as_sum;
        flags_d.ac = as_hc;
        szp_upd    = 1'b1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        result_o   = lg_y;
        flags_d.cy = 1'b0;
        flags_d.ac = 1'b0;
        szp_upd    = 1'b1;
      end
      OP_RL, OP_RR, OP_RLT, OP_RRT: begin
        result_o   = rot_y;
        flags_d.cy = rot_cy;
      end
      OP_CMA: result_o = ~acc_i;
      OP_STC: begin
        res_we_o   = 1'b0;
        flags_d.cy = 1'b1;
      end
      OP_CMC: begin
        res_we_o   = 1'b0;
        flags_d.cy = ~flags_q.cy;
      end
      OP_DAA: begin
        result_o   = daa_y;
        flags_d.ac = daa_ac;
        flags_d.cy = daa_cy;
        szp_upd    = 1'b1;
      end
      default: res_we_o = 1'b0;
    endcase
    if (szp_upd) begin
      flags_d.z = ~|result_o;
      flags_d.s = result_o[DW-1];
      flags_d.p = ~^result_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_q <= '0;
    else if (flag_we_i) flags_q <= flags_d;
  end

  assign next_flags_o = flags_d;
  assign flags_o      = flags_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [OPW-1:0] op_i,
  input logic           flag_we_i,
  input logic [DW-1:0]  result_o,
  input logic           res_we_o,
  input logic [FW-1:0]  next_flags_o,
  input logic [FW-1:0]  flags_o
);
  logic szp_op, logic_op, rot_op, incdec_op, undef_op;

  assign szp_op    = (op_i <= 5'd9) || (op_i == 5'd17);
  assign logic_op  = (op_i >= 5'd4) && (op_i <= 5'd6);
  assign rot_op    = (op_i >= 5'd10) && (op_i <= 5'd13);
  assign incdec_op = (op_i == 5'd8) || (op_i == 5'd9);
  assign undef_op  = (op_i > 5'd17);

  a_r1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == $past(next_flags_o));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  a_r2_szp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    szp_op |-> (next_flags_o[3] == (result_o == '0)) && (next_flags_o[4] == result_o[DW-1])
               && (next_flags_o[1] == ($countones(result_o) % 2 == 0)));

  a_r5_cmp_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd7) |-> !res_we_o);

  a_r6_keep_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incdec_op |-> next_flags_o[0] == flags_o[0]);

  a_r7_clr_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_op |-> (next_flags_o[0] == 1'b0) && (next_flags_o[2] == 1'b0));

  a_r8_rot_only_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_op |-> next_flags_o[4:1] == flags_o[4:1]);

  a_r9_cma_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd14) |-> next_flags_o == flags_o);

  a_r11_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_op |-> !res_we_o && (next_flags_o == flags_o));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_i         (op_i),
  .flag_we_i    (flag_we_i),
  .result_o     (result_o),
  .res_we_o     (res_we_o),
  .next_flags_o (next_flags_o),
  .flags_o      (flags_o)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/100ps
module acc_alu_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic       flag_we_i = 1'b0;
  logic [7:0] result_o;
  logic       res_we_o;
  logic [4:0] next_flags_o;
  logic [4:0] flags_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acc_alu uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op_i),
    .acc_i        (acc_i),
    .opnd_i       (opnd_i),
    .flag_we_i    (flag_we_i),
    .result_o     (result_o),
    .res_we_o     (res_we_o),
    .next_flags_o (next_flags_o),
    .flags_o      (flags_o)
  );

  typedef struct {
    int         op;
    logic [7:0] res;
    logic       we;
    logic [4:0] nf;
    logic [4:0] fl;
  } exp_t;

  exp_t       sb_q[$];
  logic [4:0] m_flags = '0;

  function automatic string tag_of(int op);
    if (op <= 1)  return "R3";
    if (op <= 3)  return "R4";
    if (op <= 6)  return "R7";
    if (op == 7)  return "R5";
    if (op <= 9)  return "R6";
    if (op <= 13) return "R8";
    if (op <= 16) return "R9";
    if (op == 17) return "R10";
    return "R11";
  endfunction

  // reference model from the requirements; flag bits s=4 z=3 ac=2 p=1 cy=0
  function automatic exp_t model(int op, int a, int b, logic [4:0] f);
    exp_t e;
    int   cy, ac, r, t, c, lo;
    bit   szp;
    cy = f[0]; ac = f[2]; r = a; szp = 0;
    e.op = op; e.we = 1'b1; e.nf = f; e.fl = f;
    case (op)
      0, 1: begin
        c = (op == 1) ? cy : 0;
        t = a + b + c; r = t & 255;
        e.nf[0] = (t > 255); e.nf[2] = ((a & 15) + (b & 15) + c) > 15; szp = 1;
      end
      2, 3, 7: begin
        c = (op == 3) ? cy : 0;
        t = a - b - c; r = t & 255;
        e.nf[0] = (t < 0); e.nf[2] = ((a & 15) - (b & 15) - c) < 0; szp = 1;
        if (op == 7) e.we = 1'b0;
      end
      4: begin r = a & b; e.nf[0] = 0; e.nf[2] = 0; szp = 1; end
      5: begin r = a ^ b; e.nf[0] = 0; e.nf[2] = 0; szp = 1; end
      6: begin r = a | b; e.nf[0] = 0; e.nf[2] = 0; szp = 1; end
      8: begin r = (a + 1) & 255; e.nf[2] = ((a & 15) == 15); szp = 1; end
      9: begin r = (a + 255) & 255; e.nf[2] = ((a & 15) == 0); szp = 1; end
      10: begin r = ((a << 1) | (a >> 7)) & 255; e.nf[0] = a >> 7; end
      11: begin r = (a >> 1) | ((a & 1) << 7); e.nf[0] = a & 1; end
      12: begin r = ((a << 1) | cy) & 255; e.nf[0] = a >> 7; end
      13: begin r = (a >> 1) | (cy << 7); e.nf[0] = a & 1; end
      14: r = (~a) & 255;
      15: begin e.we = 1'b0; e.nf[0] = 1; end
      16: begin e.we = 1'b0; e.nf[0] = !cy; end
      17: begin
        lo = a & 15; t = a; e.nf[2] = 0;
        if (lo > 9 || ac != 0) begin e.nf[2] = (lo + 6) > 15; t = a + 6; end
        if ((t >> 4) > 9 || cy != 0) begin t = t + 'h60; e.nf[0] = 1; end
        else e.nf[0] = 0;
        r = t & 255; szp = 1;
      end
      default: e.we = 1'b0;
    endcase
    e.res = r[7:0];
    if (szp) begin
      e.nf[4] = r[7];
      e.nf[3] = (r[7:0] == 8'd0);
      e.nf[1] = ($countones(r[7:0]) % 2 == 0);
    end
    return e;
  endfunction

  task automatic check(string req, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic drive(int op, int a, int b, bit we);
    exp_t e;
    @(negedge clk_i);
    op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flag_we_i = we;
    e = model(op, a, b, m_flags);
    sb_q.push_back(e);
    if (we) m_flags = e.nf;
  endtask

  // monitor: samples between edges, after the driver has pushed
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(tag_of(e.op), $sformatf("result op %0d", e.op), result_o, e.res);
        check(tag_of(e.op), $sformatf("write op %0d", e.op), res_we_o, e.we);
        check(tag_of(e.op), $sformatf("cy/ac op %0d", e.op),
              {next_flags_o[2], next_flags_o[0]}, {e.nf[2], e.nf[0]});
        if (e.op <= 9 || e.op == 17)
          check("R2", $sformatf("szp op %0d", e.op),
                {next_flags_o[4:3], next_flags_o[1]}, {e.nf[4:3], e.nf[1]});
        else
          check(tag_of(e.op), $sformatf("szp op %0d", e.op),
                {next_flags_o[4:3], next_flags_o[1]}, {e.nf[4:3], e.nf[1]});
        check("R1", "flags_o", flags_o, e.fl);
      end
    end
  end

  initial begin
    #200us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    check("R1", "flags in reset", flags_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1", "flags after release", flags_o, 0);

    // R3 wrap and nibble carry
    drive(0, 'hFF, 'h01, 1);
    drive(1, 'h0F, 'h00, 1);
    drive(0, 'h7F, 'h01, 1);
    // R4 borrow
    drive(2, 'h00, 'h01, 1);
    drive(3, 'h10, 'h00, 1);
    drive(2, 'h55, 'h55, 1);
    // R5 compare leaves flags like subtract
    drive(7, 'h20, 'h30, 1);
    drive(7, 'h30, 'h30, 1);
    // R6 carry kept across inc/dec
    drive(15, 0, 0, 1);
    drive(8, 'hFF, 0, 1);
    drive(9, 'h00, 0, 1);
    drive(9, 'h10, 0, 1);
    // R7
    drive(4, 'hF0, 'h3C, 1);
    drive(5, 'hAA, 'hAA, 1);
    drive(6, 'h81, 'h02, 1);
    // R8 rotates with carry chained
    drive(10, 'h81, 0, 1);
    drive(13, 'h02, 0, 1);
    drive(12, 'h80, 0, 1);
    drive(11, 'h01, 0, 1);
    // R9
    drive(14, 'h5A, 0, 1);
    drive(16, 0, 0, 1);
    drive(16, 0, 0, 1);
    // R10 decimal adjust corners
    drive(0, 'h09, 'h08, 1);
    drive(17, 'h11, 0, 1);
    drive(4, 0, 0, 1);
    drive(17, 'h9A, 0, 1);
    drive(4, 0, 0, 1);
    drive(17, 'hFF, 0, 1);
    drive(17, 'h00, 0, 1);
    // R11 undefined codes, flag hold with strobe low (R1)
    drive(18, 'h33, 'h44, 1);
    drive(31, 'hC3, 'h01, 1);
    drive(0, 'hFF, 'hFF, 0);
    drive(1, 'h01, 'h01, 1);

    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 40; k++) begin
        drive(op, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1) == 1);
      end
    end

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule